// File: doc/BRIEF.md
# Page-Buffered Serial Memory Command Engine

This block is the command layer of a 2K x 8 serial nonvolatile memory. A serial front end turns the wire protocol into whole bytes. It hands each received byte over with a one-cycle strobe, and it reports when chip select is released, together with a flag that says whether a byte was only partly shifted at that moment. The engine decodes the six one-byte instructions and gathers a two-byte address, of which only the low 11 bits matter. It streams array or status bytes back to the front end, which asks for each following byte with a strobe.

Write data is collected in a 32-byte page latch. When chip select is released at a legal point, the engine starts a self-timed busy period. During that period it walks the latch and writes every byte that was loaded. Before each byte is written, it asks an external protection unit whether that address may be altered. The engine holds the write-enable flag and the nonvolatile configuration bits: protect enable and the two block-protect bits. It sends the configuration bits out to the protection unit, and that unit also decides whether a status write is allowed.

Top module: `sme_top`

## Requirements
- R1: Opcodes: 0x06 sets the write-enable flag, 0x04 clears it, 0x05 streams status, 0x01 writes status, 0x03 reads the array, 0x02 writes the array. Any other first byte makes the rest of the frame have no effect.
- R2: A read sends the opcode, then a high and a low address byte, of which only bits 10:0 are used. After that, `tx_byte` presents the array byte at that address, and each `tx_next` strobe advances the address by one.
- R3: The read address wraps from 0x7FF to 0x000.
- R4: A write loads its data bytes into the page latch, starting at the in-page offset (address bits 4:0). That offset wraps from 31 to 0 inside the same page, so a later byte overwrites an earlier one. Only loaded bytes are written at commit.
- R5: A data write or a status write commits only if the frame ends with `frame_partial` low. A data write also needs at least one full data byte. A status write needs exactly one data byte. Any other ending discards the operation.
- R6: 0x06 and 0x04 take effect only if the frame holds exactly that one byte and ends with `frame_partial` low.
- R7: A commit needs the write-enable flag set. The flag clears in the same cycle that the busy period ends.
- R8: A commit holds `busy` high for exactly BUSY_CYCLES cycles. A frame whose opcode arrives while `busy` is high is ignored, unless it is a status read, and it leaves no trace in the flag, the array or the status.
- R9: The status byte is {protect-enable, 000, block-protect[1:0], write-enable, 0} while idle, and 0xFF while busy.
- R10: A status write keeps data bits 7, 3 and 2 as protect-enable and block-protect. It is refused (no busy period, nothing changes) when `sr_wr_ok` is low at the end of the frame.
- R11: At commit, each loaded byte is written only if `prot_ok` is high for its address. A refused byte is dropped, while the rest of the page is still written.
- R12: After reset, `busy` and `tx_ok` are low, and the status byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | One-cycle strobe: a full byte was received |
| rx_byte | input | 8 | Received byte |
| frame_end | input | 1 | One-cycle strobe: chip select released |
| frame_partial | input | 1 | With frame_end: a byte was only partly shifted |
| tx_next | input | 1 | Front end has taken the current output byte |
| tx_byte | output | 8 | Byte to shift out |
| tx_ok | output | 1 | An output stream is active |
| prot_addr | output | 11 | Array address being committed |
| prot_ok | input | 1 | Protection unit allows a write to prot_addr |
| sr_wr_ok | input | 1 | Protection unit allows a status write |
| blk_prot | output | 2 | Block-protect setting |
| wp_en | output | 1 | Protect-enable setting |
| busy | output | 1 | Self-timed commit in progress |

## Verification
Two functions can meet in one clock edge: the end of the busy period and the auto-clear of the write-enable flag. Both land while a status read is still streaming. The bench opens a status frame just after a commit and keeps it open across the end of the busy period. At every sample it pairs `busy` with `tx_byte`: the byte must be 0xFF while busy is high, and the idle status with the flag already clear from the first sample after busy drops. A byte with the flag still set and the busy bit clear is a failure.

// File: rtl/sme_pkg.sv
package sme_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [3:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RDAT, ST_WDAT,
    ST_SRRD, ST_SRWD, ST_SRFULL, ST_ONEOP, ST_DROP
  } fst_e;
endpackage

// File: rtl/sme_frame_ctl.sv
module sme_frame_ctl
  import sme_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_vld,
  input  logic [7:0]    rx_byte,
  input  logic          frame_end,
  input  logic          frame_partial,
  input  logic          tx_next,
  input  logic          busy,
  input  logic          wel,
  input  logic          sr_ok,
  output logic          lat_clr,
  output logic          lat_ld,
  output logic          lat_wr,
  output logic [AW-1:0] lat_addr,
  output logic [AW-1:0] rd_addr,
  output logic          st_rdat,
  output logic          st_srrd,
  output logic          set_wel,
  output logic          clr_wel,
  output logic          go_page,
  output logic          go_sr,
  output logic [2:0]    sr_bits
);
  localparam int HW = AW - 8;

  fst_e          st_q, st_n;
  logic [HW-1:0] hi_q, hi_n;
  logic [AW-1:0] rd_q, rd_n;
  logic          isw_q, isw_n;
  logic          got_q, got_n;
  logic          set_q, set_n;
  logic [2:0]    srb_q, srb_n;
  logic          aligned;

  assign aligned  = !frame_partial;
  assign lat_addr = {hi_q, rx_byte};
  assign rd_addr  = rd_q;
  assign st_rdat  = (st_q == ST_RDAT);
  assign st_srrd  = (st_q == ST_SRRD);
  assign sr_bits  = srb_q;

  always_comb begin
    st_n = st_q; hi_n = hi_q; rd_n = rd_q; isw_n = isw_q;
    got_n = got_q; set_n = set_q; srb_n = srb_q;
    lat_clr = 1'b0; lat_ld = 1'b0; lat_wr = 1'b0;
    set_wel = 1'b0; clr_wel = 1'b0; go_page = 1'b0; go_sr = 1'b0;
    if (frame_end) begin
      st_n = ST_OPC;
      unique case (st_q)
        ST_ONEOP: if (aligned) begin
          set_wel = set_q;
          clr_wel = !set_q;
        end
        ST_WDAT:   go_page = aligned && got_q && wel;
        ST_SRFULL: go_sr   = aligned && wel && sr_ok;
        default: ;
      endcase
    end else begin
      if (rx_vld) begin
        unique case (st_q)
          ST_OPC: begin
            if (busy) begin
              st_n = (rx_byte == OP_RDSR) ? ST_SRRD : ST_DROP;
            end else begin
              unique case (rx_byte)
                OP_WREN:  begin st_n = ST_ONEOP; set_n = 1'b1; end
                OP_WRDI:  begin st_n = ST_ONEOP; set_n = 1'b0; end
                OP_RDSR:  st_n = ST_SRRD;
                OP_WRSR:  st_n = ST_SRWD;
                OP_READ:  begin st_n = ST_AHI; isw_n = 1'b0; end
                OP_WRITE: begin st_n = ST_AHI; isw_n = 1'b1; lat_clr = 1'b1; end
                default:  st_n = ST_DROP;
              endcase
            end
          end
          ST_AHI: begin
            hi_n = rx_byte[HW-1:0];
            st_n = ST_ALO;
          end
          ST_ALO: begin
            if (isw_q) begin
              lat_ld = 1'b1;
              got_n  = 1'b0;
              st_n   = ST_WDAT;
            end else begin
              rd_n = lat_addr;
              st_n = ST_RDAT;
            end
          end
          ST_WDAT: begin
            lat_wr = 1'b1;
            got_n  = 1'b1;
          end
          ST_SRWD: begin
            srb_n = {rx_byte[7], rx_byte[3:2]};
            st_n  = ST_SRFULL;
          end
          ST_SRFULL, ST_ONEOP: st_n = ST_DROP;
          default: ;
        endcase
      end
      if (tx_next && st_q == ST_RDAT) rd_n = rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OPC;
      hi_q  <= '0;
      rd_q  <= '0;
      isw_q <= 1'b0;
      got_q <= 1'b0;
      set_q <= 1'b0;
      srb_q <= '0;
    end else begin
      st_q  <= st_n;
      hi_q  <= hi_n;
      rd_q  <= rd_n;
      isw_q <= isw_n;
      got_q <= got_n;
      set_q <= set_n;
      srb_q <= srb_n;
    end
  end

  AST_RD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDAT && tx_next && !frame_end && rd_q == {AW{1'b1}}) |=> (rd_q == '0)); // R3
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP && !frame_end) |=> (st_q == ST_DROP)); // R1
endmodule

// File: rtl/sme_page_latch.sv
module sme_page_latch #(
  parameter int AW = 11,
  parameter int PAGE_BYTES = 32,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int BW = AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic          wr,
  input  logic [7:0]    wr_dat,
  input  logic [PW-1:0] sw_idx,
  output logic [7:0]    sw_dat,
  output logic          sw_dirty,
  output logic [BW-1:0] base
);
  logic [PW-1:0] ptr_q, ptr_n;
  logic [BW-1:0] base_q, base_n;
  logic [7:0]    buf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] dirty_q;

  always_comb begin
    ptr_n  = ptr_q;
    base_n = base_q;
    if (ld) begin
      ptr_n  = ld_addr[PW-1:0];
      base_n = ld_addr[AW-1:PW];
    end else if (wr) begin
      ptr_n = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else begin
      ptr_q  <= ptr_n;
      base_q <= base_n;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic hit;
    assign hit = wr && (ptr_q == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dirty_q[i] <= 1'b0;
      else if (clr) dirty_q[i] <= 1'b0;
      else if (hit) dirty_q[i] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (hit) buf_q[i] <= wr_dat;
    end
  end

  assign sw_dat   = buf_q[sw_idx];
  assign sw_dirty = dirty_q[sw_idx];
  assign base     = base_q;

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ld && ptr_q == PW'(PAGE_BYTES-1)) |=> (ptr_q == '0)); // R4
endmodule

// File: rtl/sme_commit_timer.sv
module sme_commit_timer #(
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYCLES = 2500000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(BUSY_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_page,
  input  logic          go_sr,
  output logic          busy,
  output logic          sweep_on,
  output logic [PW-1:0] sweep_idx,
  output logic          done
);
  logic          busy_q, busy_n;
  logic          sw_q, sw_n;
  logic [PW-1:0] idx_q, idx_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_n = busy_q; sw_n = sw_q; idx_n = idx_q; cnt_n = cnt_q;
    if (go_page || go_sr) begin
      busy_n = 1'b1;
      cnt_n  = CW'(BUSY_CYCLES - 1);
      idx_n  = '0;
      sw_n   = go_page;
    end else if (busy_q) begin
      if (done) begin
        busy_n = 1'b0;
        sw_n   = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
      if (sw_q) begin
        if (idx_q == PW'(PAGE_BYTES-1)) sw_n = 1'b0;
        else                            idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sw_q   <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      sw_q   <= sw_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy      = busy_q;
  assign sweep_on  = sw_q;
  assign sweep_idx = idx_q;

  AST_SWEEP_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_q |-> busy_q); // R8
  AST_NO_START_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !(go_page || go_sr)); // R8
endmodule

// File: rtl/sme_mem_array.sv
module sme_mem_array #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[wa] <= wd;
  end

  assign rd = mem_q[ra];
endmodule

// File: rtl/sme_top.sv
module sme_top #(
  parameter int MEM_BYTES = 2048,
  parameter int PAGE_BYTES = 32,
  parameter int BUSY_CYCLES = 2500000,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int BW = AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_vld,
  input  logic [7:0]    rx_byte,
  input  logic          frame_end,
  input  logic          frame_partial,
  input  logic          tx_next,
  output logic [7:0]    tx_byte,
  output logic          tx_ok,
  output logic [AW-1:0] prot_addr,
  input  logic          prot_ok,
  input  logic          sr_wr_ok,
  output logic [1:0]    blk_prot,
  output logic          wp_en,
  output logic          busy
);
  logic          lat_clr, lat_ld, lat_wr;
  logic [AW-1:0] lat_addr, rd_addr;
  logic          st_rdat, st_srrd;
  logic          set_wel, clr_wel, go_page, go_sr;
  logic [2:0]    sr_bits;
  logic [7:0]    sw_dat, mem_rd;
  logic          sw_dirty, sweep_on, done, busy_w, mem_we;
  logic [PW-1:0] sweep_idx;
  logic [BW-1:0] base;
  logic          wel_q, wel_n;
  logic [2:0]    cfg_q, cfg_n;
  logic [7:0]    status;

  sme_frame_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .frame_end(frame_end), .frame_partial(frame_partial), .tx_next(tx_next),
    .busy(busy_w), .wel(wel_q), .sr_ok(sr_wr_ok),
    .lat_clr(lat_clr), .lat_ld(lat_ld), .lat_wr(lat_wr), .lat_addr(lat_addr),
    .rd_addr(rd_addr), .st_rdat(st_rdat), .st_srrd(st_srrd),
    .set_wel(set_wel), .clr_wel(clr_wel), .go_page(go_page), .go_sr(go_sr),
    .sr_bits(sr_bits)
  );

  sme_page_latch #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(lat_clr), .ld(lat_ld), .ld_addr(lat_addr),
    .wr(lat_wr), .wr_dat(rx_byte), .sw_idx(sweep_idx), .sw_dat(sw_dat),
    .sw_dirty(sw_dirty), .base(base)
  );

  sme_commit_timer #(.PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go_page(go_page), .go_sr(go_sr),
    .busy(busy_w), .sweep_on(sweep_on), .sweep_idx(sweep_idx), .done(done)
  );

  assign prot_addr = {base, sweep_idx};
  assign mem_we    = sweep_on && sw_dirty && prot_ok;

  sme_mem_array #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .wa(prot_addr), .wd(sw_dat), .ra(rd_addr), .rd(mem_rd)
  );

  always_comb begin
    wel_n = wel_q;
    cfg_n = cfg_q;
    if (done)         wel_n = 1'b0;
    else if (set_wel) wel_n = 1'b1;
    else if (clr_wel) wel_n = 1'b0;
    if (go_sr) cfg_n = sr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      wel_q <= wel_n;
      cfg_q <= cfg_n;
    end
  end

  assign status   = busy_w ? 8'hFF : {cfg_q[2], 3'b000, cfg_q[1:0], wel_q, 1'b0};
  assign tx_byte  = st_srrd ? status : mem_rd;
  assign tx_ok    = st_rdat || st_srrd;
  assign blk_prot = cfg_q[1:0];
  assign wp_en    = cfg_q[2];
  assign busy     = busy_w;

  AST_WEL_GONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_w) |-> !wel_q); // R7
  AST_MEM_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy_w); // R8
  AST_CFG_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |=> (busy_w || $stable(cfg_q))); // R10
endmodule

// File: tb/sme_top_bench.sv
`timescale 1ns/1ps
module sme_top_bench;
  localparam int BUSY = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_vld = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       frame_end = 1'b0;
  logic       frame_partial = 1'b0;
  logic       tx_next = 1'b0;
  logic       sr_wr_ok = 1'b1;
  logic [7:0] tx_byte;
  logic       tx_ok, busy, wp_en, prot_ok;
  logic [10:0] prot_addr;
  logic [1:0] blk_prot;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [2048];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  sme_top #(.BUSY_CYCLES(BUSY)) u_sme_top (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .frame_end(frame_end), .frame_partial(frame_partial), .tx_next(tx_next),
    .tx_byte(tx_byte), .tx_ok(tx_ok), .prot_addr(prot_addr), .prot_ok(prot_ok),
    .sr_wr_ok(sr_wr_ok), .blk_prot(blk_prot), .wp_en(wp_en), .busy(busy)
  );

  // protection unit model: 1 = top quarter, 2 = top half, 3 = all
  always_comb begin
    unique case (blk_prot)
      2'd0: prot_ok = 1'b1;
      2'd1: prot_ok = (prot_addr < 11'h600);
      2'd2: prot_ok = (prot_addr < 11'h400);
      default: prot_ok = 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(tx_ok && tx_byte == e, t, {tx_ok, tx_byte}, {1'b1, e});
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_vld = 1'b1; rx_byte = b;
    @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic fend(input bit part);
    @(negedge clk); frame_end = 1'b1; frame_partial = part;
    @(negedge clk); frame_end = 1'b0; frame_partial = 1'b0;
  endtask

  task automatic take(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    tx_next = 1'b1;
    @(negedge clk); tx_next = 1'b0;
  endtask

  task automatic op1(input logic [7:0] op);
    send(op); fend(1'b0);
  endtask

  task automatic rdsr(input logic [7:0] e, input string t);
    send(8'h05); take(e, t); fend(1'b0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_page(input logic [15:0] a, input int n, input logic [7:0] d0);
    logic [10:0] base;
    send(8'h02); send(a[15:8]); send(a[7:0]);
    base = a[10:0];
    for (int i = 0; i < n; i++) begin
      logic [10:0] wa;
      wa = {base[10:5], 5'(base[4:0] + i)};
      send(d0 + 8'(i));
      if (blk_prot == 2'd0 || (blk_prot == 2'd1 && wa < 11'h600) ||
          (blk_prot == 2'd2 && wa < 11'h400))
        model[wa] = d0 + 8'(i);
    end
    fend(1'b0);
  endtask

  task automatic rd_chk(input logic [15:0] a, input int n, input string t);
    logic [10:0] ra;
    ra = a[10:0];
    send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      take(model[ra], t);
      ra = ra + 11'd1;
    end
    fend(1'b0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(busy == 1'b0 && tx_ok == 1'b0, "R12 idle", {busy, tx_ok}, 0);
    rdsr(8'h00, "R12 status after reset");
    // R6 / R9 write enable flag
    op1(8'h06);
    rdsr(8'h02, "R6 R9 flag set");
    op1(8'h04);
    rdsr(8'h00, "R6 flag cleared");
    send(8'h06); send(8'h00); fend(1'b0);
    rdsr(8'h00, "R6 extra byte ignored");
    send(8'h06); fend(1'b1);
    rdsr(8'h00, "R6 partial end ignored");
    // R1 unknown opcode
    send(8'hAB); send(8'h06); fend(1'b0);
    rdsr(8'h00, "R1 unknown opcode drops frame");
    // R2 R8 write with high address bits, measure busy
    op1(8'h06);
    wr_page(16'hF810, 3, 8'h11);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    chk(cnt == BUSY, "R8 busy length", cnt, BUSY);
    rdsr(8'h00, "R7 flag auto-cleared");
    rd_chk(16'h0010, 3, "R2 stream read");
    rd_chk(16'h2011, 1, "R2 upper address bits ignored");
    // R7 no flag, no commit
    send(8'h02); send(8'h00); send(8'h10); send(8'h99); fend(1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R7 no commit without flag", busy, 0);
    rd_chk(16'h0010, 1, "R7 data unchanged");
    // R5 partial ending and empty write
    op1(8'h06);
    send(8'h02); send(8'h00); send(8'h10); send(8'h99); fend(1'b1);
    @(negedge clk);
    chk(busy == 1'b0, "R5 partial end discards", busy, 0);
    send(8'h02); send(8'h00); send(8'h10); fend(1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R5 no data byte discards", busy, 0);
    rdsr(8'h02, "R5 flag kept after discard");
    rd_chk(16'h0010, 1, "R5 data unchanged");
    // R3 array wrap on read
    wr_page(16'h07FE, 2, 8'hA1); wait_idle();
    op1(8'h06); wr_page(16'h0000, 1, 8'hB0); wait_idle();
    rd_chk(16'h07FE, 3, "R3 read wraps to 0");
    // R4 page wrap on write
    op1(8'h06); wr_page(16'h003E, 34, 8'h40); wait_idle();
    rd_chk(16'h0020, 32, "R4 page wrap overwrite");
    // R8 ignored frames during busy, status 0xFF
    op1(8'h06); wr_page(16'h0100, 1, 8'h5A);
    send(8'h03); send(8'h01); send(8'h00);
    @(negedge clk);
    chk(tx_ok == 1'b0, "R8 read ignored while busy", tx_ok, 0);
    fend(1'b0);
    op1(8'h06);
    rdsr(8'hFF, "R9 status while busy");
    wait_idle();
    rdsr(8'h00, "R8 busy-time enable had no effect");
    rd_chk(16'h0100, 1, "R8 commit data");
    // R10 status write refused / malformed / accepted
    sr_wr_ok = 1'b0;
    op1(8'h06); send(8'h01); send(8'h8C); fend(1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R10 refused status write", busy, 0);
    sr_wr_ok = 1'b1;
    send(8'h01); send(8'h8C); send(8'h00); fend(1'b0);
    rdsr(8'h02, "R5 status write with extra byte discarded");
    send(8'h01); send(8'hFF); fend(1'b0);
    chk(busy == 1'b1, "R10 status write commits", busy, 1);
    wait_idle();
    rdsr(8'h8C, "R10 masked status");
    chk(blk_prot == 2'd3 && wp_en == 1'b1, "R10 config outputs", {wp_en, blk_prot}, 7);
    // R11 protection
    op1(8'h06); wr_page(16'h0010, 1, 8'h77); wait_idle();
    rd_chk(16'h0010, 1, "R11 fully protected write dropped");
    op1(8'h06); send(8'h01); send(8'h08); fend(1'b0); wait_idle();
    rdsr(8'h08, "R10 half protection set");
    op1(8'h06); wr_page(16'h03F0, 1, 8'h55); wait_idle();
    rd_chk(16'h03F0, 1, "R11 low half still writable");
    op1(8'h06); wr_page(16'h07FE, 1, 8'h66); wait_idle();
    rd_chk(16'h07FE, 1, "R11 top half dropped");
    // R7 R9 busy end and flag clear in one edge, seen through a status stream
    op1(8'h06); wr_page(16'h0200, 1, 8'h01);
    send(8'h05);
    begin
      bit ok;
      int seen_idle;
      ok = 1'b1; seen_idle = 0;
      while (seen_idle < 3) begin
        if (busy) ok &= (tx_byte == 8'hFF);
        else begin ok &= (tx_byte == 8'h08); seen_idle++; end
        @(negedge clk);
      end
      chk(ok, "R7 R9 status across busy end", tx_byte, 8'h08);
    end
    fend(1'b0);
    rd_chk(16'h0200, 1, "R4 single byte commit");
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule